// File: doc/BRIEF.md
# I2C SCL Rate Divider

This block turns a fixed core clock into the timing reference that an I2C bus engine needs. Software writes a 7-bit baud setting. The divider then produces a single-cycle sample tick that runs at ten times the SCL rate, along with a free-running indicator of whether the current SCL period is in its low half or its high half. The bus engine uses the tick to step its bit state machine and uses the phase indicator to drive or sample the clock line.

The division happens in two stages. A power-of-two prescaler emits an enable pulse once every 2^(N+1) core cycles. A second counter, which runs to M+1, advances only on that enable, and its terminal count forms the sample tick. Ten ticks make one SCL period, so SCL = core / (10 × (M+1) × 2^(N+1)). A build parameter can remove the extra factor of two so that the prescaler divides by 2^N instead. Choosing M and N for a target bus rate is left to software.

Writing a new baud value restarts the prescaler, the linear counter and the SCL phase from zero. The new rate therefore applies at once, and no shortened tick can appear between the old rate and the new one.

Top module: `scl_rate_div`

## Requirements
- R1: After reset the baud setting is 0x44 (M=8, N=4), tick_o and scl_high_o are low, and in the default build the first tick is visible 288 clock cycles after reset is released (the release cycle counts as the first).
- R2: The baud word carries M in bits 6:3 and N in bits 2:0. For example, 0x19 gives M=3 and N=1.
- R3: With EXP_OFFSET=1 (the default), tick_o pulses exactly once every (M+1)×2^(N+1) clock cycles.
- R4: With EXP_OFFSET=0, tick_o pulses exactly once every (M+1)×2^N clock cycles. With M=0 and N=0 it is high on every cycle.
- R5: When the tick interval is longer than one cycle, tick_o is high for only one cycle per interval, and it is only high on a cycle where the prescaler enable is also active.
- R6: scl_high_o stays low for 5 ticks and then high for 5 ticks, so one SCL period lasts 10 tick intervals. It changes only in the cycle after a tick.
- R7: A baud write restarts the division. The first tick after the write is visible exactly D_new cycles later, where D_new is the interval for the new setting and the cycle after the write edge counts as the first. No tick appears in between, even if the write arrives partway through an interval.
- R8: A baud write returns the SCL phase to the start of its low half, so scl_high_o reads 0 in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| baud_we_i | input | 1 | Write strobe for the baud setting |
| baud_wdata_i | input | 7 | New baud setting: M in bits 6:3, N in bits 2:0 |
| tick_o | output | 1 | Single-cycle sample tick at ten times the SCL rate |
| scl_high_o | output | 1 | 1 during the high half of the SCL period, 0 during the low half |

## Verification
The bench builds two copies of the divider side by side: one with the default exponent convention (EXP_OFFSET=1) and one with EXP_OFFSET=0. Both use ten ticks per SCL period. Between them they cover both prescaler conventions, including the divide-by-one corner case that exists only in the second build.

Each copy is swept through every exponent value for three linear factors, and through every linear factor for the three smallest exponents. At each setting the bench measures both the first interval after the restart and the steady-state interval, so the longest interval, 4096 cycles, is included in the sweep. A mid-interval rewrite, a rewrite during the high half of SCL, and a field-swap probe complete the restart and layout checks.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    localparam int M_W    = 4;
    localparam int N_W    = 3;
    localparam int BAUD_W = M_W + N_W;

    // M occupies the upper bits, N the lower bits of the baud word
    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } baud_t;

    typedef struct packed {
        baud_t baud;
    } top_state_t;
endpackage

// File: rtl/scl_pow2_prescale.sv
module scl_pow2_prescale #(
    parameter int N_W        = 3,
    parameter int EXP_OFFSET = 1,
    localparam int CNT_W     = (1 << N_W) - 1 + EXP_OFFSET
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           restart_i,
    input  logic [N_W-1:0] exp_i,
    output logic           en_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;
    logic             at_limit;

    always_comb begin
        // limit = 2^(exp+offset) - 1, built bit by bit
        for (int i = 0; i < CNT_W; i++) begin
            limit[i] = (i < (int'(exp_i) + EXP_OFFSET));
        end
        at_limit = (cnt_q == limit);
        if (restart_i) begin
            cnt_d = '0;
        end else if (at_limit) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign en_o = at_limit;
endmodule

// File: rtl/scl_lin_divider.sv
module scl_lin_divider #(
    parameter int M_W = 4
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           restart_i,
    input  logic           step_i,
    input  logic [M_W-1:0] factor_i,
    output logic           tick_o
);
    logic [M_W-1:0] cnt_d, cnt_q;
    logic           at_last;

    always_comb begin
        at_last = (cnt_q == factor_i);
        cnt_d   = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d = at_last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign tick_o = step_i & at_last;
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
    parameter int TICKS   = 10,
    localparam int PH_W   = $clog2(TICKS)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic tick_i,
    output logic high_o
);
    logic [PH_W-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (restart_i) begin
            ph_d = '0;
        end else if (tick_i) begin
            ph_d = (ph_q == PH_W'(TICKS - 1)) ? '0 : ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ph_q <= '0;
        else         ph_q <= ph_d;
    end

    assign high_o = (ph_q >= PH_W'(TICKS / 2));
endmodule

// File: rtl/scl_rate_div.sv
module scl_rate_div
    import scl_div_pkg::*;
#(
    parameter int          TICKS_PER_SCL = 10,
    parameter int          EXP_OFFSET    = 1,
    parameter logic [6:0]  RESET_BAUD    = 7'h44
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              baud_we_i,
    input  logic [BAUD_W-1:0] baud_wdata_i,
    output logic              tick_o,
    output logic              scl_high_o
);
    top_state_t state_d, state_q;
    logic       pre_en;

    always_comb begin
        state_d = state_q;
        if (baud_we_i) begin
            state_d.baud = baud_t'(baud_wdata_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= top_state_t'(RESET_BAUD);
        else         state_q <= state_d;
    end

    scl_pow2_prescale #(
        .N_W        (N_W),
        .EXP_OFFSET (EXP_OFFSET)
    ) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (baud_we_i),
        .exp_i     (state_q.baud.n),
        .en_o      (pre_en)
    );

    scl_lin_divider #(
        .M_W (M_W)
    ) u_lin (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (baud_we_i),
        .step_i    (pre_en),
        .factor_i  (state_q.baud.m),
        .tick_o    (tick_o)
    );

    scl_phase_gen #(
        .TICKS (TICKS_PER_SCL)
    ) u_phase (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (baud_we_i),
        .tick_i    (tick_o),
        .high_o    (scl_high_o)
    );
endmodule

// File: rtl/scl_rate_div_chk.sv
module scl_rate_div_chk #(
    parameter int EXP_OFFSET = 1
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       baud_we_i,
    input logic [6:0] baud_wdata_i,
    input logic       tick_o,
    input logic       scl_high_o,
    input logic       pre_en
);
    // R5: a tick only ever coincides with a prescaler enable
    p_tick_on_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> pre_en);

    // R7: no tick in the cycle after a restart unless the interval is one cycle
    p_restart_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (baud_we_i && ((EXP_OFFSET != 0) || (baud_wdata_i != 7'h00))) |=> !tick_o);

    // R8: a restart puts SCL back into its low half
    p_restart_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        baud_we_i |=> !scl_high_o);

    // R6: the SCL phase moves only after a tick
    p_scl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_o && !baud_we_i) |=> $stable(scl_high_o));
endmodule

bind scl_rate_div scl_rate_div_chk #(.EXP_OFFSET(EXP_OFFSET)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .baud_we_i    (baud_we_i),
    .baud_wdata_i (baud_wdata_i),
    .tick_o       (tick_o),
    .scl_high_o   (scl_high_o),
    .pre_en       (pre_en)
);

// File: tb/scl_rate_div_bench.sv
module scl_rate_div_bench;
    localparam int LIM = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we0 = 1'b0, we1 = 1'b0;
    logic [6:0] wdata = 7'h00;
    logic       tick0, tick1, scl0, scl1;
    int         checks = 0;
    int         fails = 0;

    always #2 clk = ~clk;

    scl_rate_div u_scl_rate_div (
        .clk_i(clk), .rst_ni(rst_n), .baud_we_i(we0), .baud_wdata_i(wdata),
        .tick_o(tick0), .scl_high_o(scl0));

    scl_rate_div #(.EXP_OFFSET(0)) u_scl_rate_div_alt (
        .clk_i(clk), .rst_ni(rst_n), .baud_we_i(we1), .baud_wdata_i(wdata),
        .tick_o(tick1), .scl_high_o(scl1));

    function automatic logic tk(input int inst);
        return (inst != 0) ? tick1 : tick0;
    endfunction

    function automatic int exp_d(input int off, input logic [6:0] b);
        return (int'(b[6:3]) + 1) << (int'(b[2:0]) + off);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // write, leaving the first post-restart state visible
    task automatic wr(input int inst, input logic [6:0] b);
        wdata = b;
        if (inst != 0) we1 = 1'b1; else we0 = 1'b1;
        step();
        we0 = 1'b0; we1 = 1'b0;
    endtask

    task automatic measure(input int inst, input logic [6:0] b, input string req);
        int c;
        int d;
        d = exp_d((inst != 0) ? 0 : 1, b);
        wr(inst, b);
        c = 0;
        while (!tk(inst) && c < LIM) begin step(); c++; end
        check(c + 1 == d, req, c + 1, d);
        step();
        c = 1;
        while (!tk(inst) && c < LIM) begin step(); c++; end
        check(c == d, req, c, d);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int c;
        int ticks;
        int bad;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and first interval from reset value 0x44
        check(tick0 == 1'b0, "R1 tick", int'(tick0), 0);
        check(scl0 == 1'b0, "R1 scl", int'(scl0), 0);
        c = 0;
        while (!tick0 && c < LIM) begin step(); c++; end
        check(c + 1 == 288, "R1 first tick", c + 1, 288);

        // R2: 0x19 -> M=3, N=1 -> 16 cycles in default build
        measure(0, 7'h19, "R2");

        // R3 / R4 sweeps
        for (int n = 0; n < 8; n++) begin
            for (int k = 0; k < 3; k++) begin
                logic [3:0] m;
                m = (k == 0) ? 4'd0 : (k == 1) ? 4'd5 : 4'd15;
                measure(0, {m, 3'(n)}, "R3");
                measure(1, {m, 3'(n)}, "R4");
            end
        end
        for (int n = 0; n < 3; n++) begin
            for (int m = 0; m < 16; m++) begin
                measure(0, {4'(m), 3'(n)}, "R3");
                measure(1, {4'(m), 3'(n)}, "R4");
            end
        end

        // R5: baud 0 in default build -> tick on every second cycle
        wr(0, 7'h00);
        bad = 0;
        for (int t = 0; t < 12; t++) begin
            if (tick0 != ((t % 2) == 1)) bad++;
            step();
        end
        check(bad == 0, "R5 pulse", bad, 0);

        // R6: SCL phase over 30 ticks at M=1,N=1 (8 cycles per tick)
        wr(0, 7'h09);
        ticks = 0;
        bad = 0;
        for (int t = 0; t < 30 * 8; t++) begin
            if (scl0 != ((ticks % 10) >= 5)) bad++;
            if (tick0) ticks++;
            step();
        end
        check(bad == 0, "R6 phase", bad, 0);
        check(ticks == 30, "R6 ticks", ticks, 30);

        // R8: write while SCL is high returns it low
        c = 0;
        while (!scl0 && c < LIM) begin step(); c++; end
        check(scl0 == 1'b1, "R8 reached high", int'(scl0), 1);
        wr(0, 7'h09);
        check(scl0 == 1'b0, "R8 low after write", int'(scl0), 0);

        // R7: write partway through a long interval, no runt tick
        wr(0, 7'h7F);
        repeat (37) step();
        wr(0, 7'h11);
        c = 0;
        while (!tick0 && c < LIM) begin step(); c++; end
        check(c + 1 == 12, "R7 restart", c + 1, 12);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule